// File: doc/BRIEF.md
# Cache Region Maintenance Sequencer

This block does maintenance work on a shared second-level cache. It can flush, invalidate, or flush and then invalidate every cache line that covers a physical address range. It can also flush or invalidate the whole cache. Software sets it up through a small register port. It first writes a control word, which selects the operation and the flush-before-invalidate mode. It then writes the exclusive end address and then the start address. The write of the low start word launches the walk.

While it runs, the engine gives the tag/data arrays one line-aligned address at a time on a valid/acknowledge request port. It holds each request until it is acknowledged, then moves to the next line. A busy flag in the control word stays set for the whole walk, and software polls that flag. A disable bit in the control word sends normal accesses around the cache through `cache_bypass`.

Register map (word index on `reg_addr`):

| Index | Register |
|-------|----------|
| 0 | control word |
| 1 | low word of the end address |
| 2 | high bits of the end address |
| 3 | low word of the start address (trigger) |
| 4 | high bits of the start address |
| 5 | invalidate-all command |
| 6 | flush-all command |

Reads are combinational and always allowed.

Top module: `cache_rgn_maint`

## Requirements
- R1: After reset:
  - the control word reads 0, with busy clear, mode 0, op field 0 and disable 0;
  - `mreq_valid` is low;
  - `cache_bypass` is low.
- R2: A region walk starts when index 3 is written and the end line is above the start line.
  - The start line is `{start_hi, start_lo} >> log2(LINE_BYTES)` and the end line is formed the same way. Address bits below the line size are ignored.
  - One request is issued for each line from the start line up to, but not including, the end line, in ascending order.
  - Each `mreq_addr` has its low log2(LINE_BYTES) bits at zero, and `mreq_whole` is 0.
- R3: If the end line is equal to or below the start line, a write to index 3 issues no request and leaves busy clear.
- R4: The op field sits in control bits 11..9 and the mode bit in control bit 6. They set `mreq_op` as follows:
  - op field 001 with mode 0 gives 2'b10 (discard);
  - op field 001 with mode 1 gives 2'b11 (flush then invalidate);
  - any other op field value gives 2'b01 (flush).
- R5: Index 2 and index 4 hold address bits PA_W-1..32 of the end and the start. These must be written before their low words, and a walk above 4 GiB uses them.
- R6: A whole-cache walk starts when index 5 or index 6 is written with bit 0 set. Writing 0 to either index has no effect.
  - The walk issues SETS requests with `mreq_whole` at 1, where `mreq_addr` is the set index shifted left by log2(LINE_BYTES).
  - Index 6 gives op 2'b01. Index 5 gives 2'b10 or 2'b11, depending on the mode bit.
- R7: Busy (control bit 8) is set from the clock edge of the trigger write until the final acknowledge. It reads 0 in the cycle after that final acknowledge, and `mreq_valid` falls at the same time.
- R8: While `mreq_valid` is high and `mreq_ack` is low, `mreq_addr`, `mreq_op` and `mreq_whole` hold their values. After each acknowledge, the next address is the previous one plus LINE_BYTES.
- R9: Every register write made while busy is set is ignored. This covers address registers, the control word and triggers, and it is checked by reading back and by the number of requests.
- R10: Control bit 0 drives `cache_bypass`. Setting it does not suppress a maintenance walk that is launched later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| mreq_valid | output | 1 | Maintenance request pending |
| mreq_addr | output | PA_W | Line-aligned address or set index of the request |
| mreq_op | output | 2 | 01 flush, 10 invalidate, 11 flush then invalidate |
| mreq_whole | output | 1 | Request belongs to a whole-cache walk |
| mreq_ack | input | 1 | Array accepts the current request |
| cache_bypass | output | 1 | Normal accesses bypass the cache |

## Verification
If the walk counter is wrong, the effect shows on `mreq_addr` at the next acknowledge. The address either skips a line, repeats a line, or loses its line alignment. If the end comparison is wrong, the walk stops one line early, stops one line late, or starts on an empty range. All of these show up in the number of requests seen before `mreq_valid` falls. If the busy flag is wrong, busy either stays up after the last acknowledge or a late register write gets through. In both cases the next read of the control word or of an address register shows it, within one cycle.

// File: rtl/cache_rgn_maint.sv
`timescale 1ns/1ps
module cache_rgn_maint #(
  parameter int PA_W       = 40,
  parameter int LINE_BYTES = 64,
  parameter int SETS       = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [2:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            mreq_valid,
  output logic [PA_W-1:0] mreq_addr,
  output logic [1:0]      mreq_op,
  output logic            mreq_whole,
  input  logic            mreq_ack,
  output logic            cache_bypass
);
  localparam int LSH = $clog2(LINE_BYTES);
  localparam int LW  = PA_W - LSH;
  localparam int HW  = PA_W - 32;
  localparam logic [1:0] OP_FL = 2'b01, OP_IV = 2'b10, OP_FI = 2'b11;

  logic          dis_q, mode_q, busy_q, whole_q;
  logic [2:0]    opf_q;
  logic [HW-1:0] endhi_q, sthi_q;
  logic [31:0]   endlo_q, stlo_q;
  logic [LW-1:0] cur_q, last_q;
  logic [1:0]    op_q;

  logic            wr_ok, rgn_go, all_go;
  logic [PA_W-1:0] new_start, end_full;
  logic [LW-1:0]   sline, eline;
  logic [1:0]      inv_op;

  assign wr_ok     = reg_wr & ~busy_q;
  assign new_start = {sthi_q, reg_wdata};
  assign end_full  = {endhi_q, endlo_q};
  assign sline     = new_start[PA_W-1:LSH];
  assign eline     = end_full[PA_W-1:LSH];
  assign rgn_go    = wr_ok && reg_addr == 3'd3 && eline > sline;
  assign all_go    = wr_ok && (reg_addr == 3'd5 || reg_addr == 3'd6) && reg_wdata[0];
  assign inv_op    = mode_q ? OP_FI : OP_IV;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q <= 1'b0; mode_q <= 1'b0; opf_q <= 3'd0;
      endhi_q <= '0; endlo_q <= '0; sthi_q <= '0; stlo_q <= '0;
    end else if (wr_ok) begin
      case (reg_addr)
        3'd0: begin
          dis_q  <= reg_wdata[0];
          mode_q <= reg_wdata[6];
          opf_q  <= reg_wdata[11:9];
        end
        3'd1: endlo_q <= reg_wdata;
        3'd2: endhi_q <= reg_wdata[HW-1:0];
        3'd3: stlo_q  <= reg_wdata;
        3'd4: sthi_q  <= reg_wdata[HW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; whole_q <= 1'b0; op_q <= OP_FL;
      cur_q <= '0; last_q <= '0;
    end else if (rgn_go) begin
      busy_q  <= 1'b1;
      whole_q <= 1'b0;
      cur_q   <= sline;
      last_q  <= eline - LW'(1);
      op_q    <= (opf_q == 3'd1) ? inv_op : OP_FL;
    end else if (all_go) begin
      busy_q  <= 1'b1;
      whole_q <= 1'b1;
      cur_q   <= '0;
      last_q  <= LW'(SETS - 1);
      op_q    <= (reg_addr == 3'd5) ? inv_op : OP_FL;
    end else if (busy_q && mreq_ack) begin
      if (cur_q == last_q) busy_q <= 1'b0;
      else                 cur_q  <= cur_q + LW'(1);
    end
  end

  assign mreq_valid   = busy_q;
  assign mreq_addr    = {cur_q, {LSH{1'b0}}};
  assign mreq_op      = op_q;
  assign mreq_whole   = whole_q;
  assign cache_bypass = dis_q;

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {20'd0, opf_q, busy_q, 1'b0, mode_q, 5'd0, dis_q};
      3'd1:    reg_rdata = endlo_q;
      3'd2:    reg_rdata = 32'(endhi_q);
      3'd3:    reg_rdata = stlo_q;
      3'd4:    reg_rdata = 32'(sthi_q);
      default: reg_rdata = 32'd0;
    endcase
  end
endmodule

module cache_rgn_maint_chk #(
  parameter int PA_W       = 40,
  parameter int LINE_BYTES = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr,
  input logic [2:0]      reg_addr,
  input logic [31:0]     reg_wdata,
  input logic            mreq_valid,
  input logic [PA_W-1:0] mreq_addr,
  input logic [1:0]      mreq_op,
  input logic            mreq_whole,
  input logic            mreq_ack,
  input logic            cache_bypass
);
  localparam int LSH = $clog2(LINE_BYTES);

  // R2
  line_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid |-> mreq_addr[LSH-1:0] == '0);

  // R8
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && !mreq_ack |=> mreq_valid && $stable(mreq_addr) && $stable(mreq_op) && $stable(mreq_whole));

  // R8
  step_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && mreq_ack |=> !mreq_valid || mreq_addr == $past(mreq_addr) + PA_W'(LINE_BYTES));

  // R7
  no_self_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mreq_valid && !(reg_wr && (reg_addr == 3'd3 || reg_addr == 3'd5 || reg_addr == 3'd6)) |=> !mreq_valid);

  // R9
  bypass_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid |=> $stable(cache_bypass));

  // R4
  op_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid |-> mreq_op != 2'b00);
endmodule

bind cache_rgn_maint cache_rgn_maint_chk #(.PA_W(PA_W), .LINE_BYTES(LINE_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .mreq_valid(mreq_valid), .mreq_addr(mreq_addr), .mreq_op(mreq_op),
  .mreq_whole(mreq_whole), .mreq_ack(mreq_ack), .cache_bypass(cache_bypass)
);

// File: tb/sim_cache_rgn_maint.sv
`timescale 1ns/1ps
module sim_cache_rgn_maint;
  localparam int PA_W = 40, LB = 64, LSH = 6, SETS = 64;

  logic clk = 0, rst_n = 0, reg_wr = 0, mreq_ack = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic mreq_valid, mreq_whole, cache_bypass;
  logic [PA_W-1:0] mreq_addr;
  logic [1:0] mreq_op;

  int checks = 0, fails = 0;
  logic [PA_W-1:0] ga [0:255];
  logic [1:0] gop [0:255];
  logic gwh [0:255];

  always #4 clk = ~clk;

  cache_rgn_maint #(.PA_W(PA_W), .LINE_BYTES(LB), .SETS(SETS)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mreq_valid(mreq_valid), .mreq_addr(mreq_addr), .mreq_op(mreq_op),
    .mreq_whole(mreq_whole), .mreq_ack(mreq_ack), .cache_bypass(cache_bypass));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic logic [1:0] exp_op(input logic [2:0] opf, input bit mode);
    if (opf == 3'd1) return mode ? 2'b11 : 2'b10;
    return 2'b01;
  endfunction

  task automatic collect(output int n, output bit tail_ok);
    int guard = 0;
    bit prev = 0;
    n = 0;
    while (mreq_valid && guard < 20000 && n < 256) begin
      mreq_ack = ($urandom % 3) != 0;
      if (mreq_ack) begin
        ga[n] = mreq_addr; gop[n] = mreq_op; gwh[n] = mreq_whole; n++;
      end
      prev = mreq_ack;
      @(negedge clk);
      guard++;
    end
    mreq_ack = 0;
    tail_ok = (n == 0) || prev;
  endtask

  task automatic region(input logic [PA_W-1:0] s, input logic [PA_W-1:0] e,
                        input logic [2:0] opf, input bit mode, input bit dis, input string req);
    logic [31:0] d;
    logic [PA_W-1:0] sl, el;
    int expn, n;
    bit tail, ok;
    sl = s >> LSH; el = e >> LSH;
    expn = (el > sl) ? int'(el - sl) : 0;
    wr(3'd0, {20'd0, opf, 2'b00, mode, 5'd0, dis});
    wr(3'd2, 32'(e[PA_W-1:32]));
    wr(3'd1, e[31:0]);
    wr(3'd4, 32'(s[PA_W-1:32]));
    wr(3'd3, s[31:0]);
    rd(3'd0, d);
    chk(d[8] == (expn > 0), {req, " R7 busy after trigger"}, d[8], expn > 0);
    collect(n, tail);
    chk(n == expn, {req, " line count"}, n, expn);
    ok = 1;
    for (int i = 0; i < n && i < 256; i++)
      if (ga[i] != ((sl + PA_W'(i)) << LSH) || gop[i] != exp_op(opf, mode) || gwh[i]) ok = 0;
    chk(ok, {req, " R2 R4 R8 addresses/op"}, n > 0 ? ga[0] : 0, sl << LSH);
    chk(tail, {req, " R7 busy drops after final ack"}, tail, 1);
    rd(3'd0, d);
    chk(d[8] == 0, {req, " R7 busy clear at end"}, d[8], 0);
  endtask

  task automatic whole(input logic [2:0] a, input bit mode, input string req);
    logic [31:0] d;
    int n;
    bit tail, ok;
    logic [1:0] eop;
    eop = (a == 3'd5) ? (mode ? 2'b11 : 2'b10) : 2'b01;
    wr(3'd0, {20'd0, 3'd0, 2'b00, mode, 5'd0, 1'b0});
    wr(a, 32'd1);
    rd(3'd0, d);
    chk(d[8] == 1, {req, " R7 busy"}, d[8], 1);
    collect(n, tail);
    chk(n == SETS, {req, " R6 count"}, n, SETS);
    ok = 1;
    for (int i = 0; i < n && i < 256; i++)
      if (ga[i] != (PA_W'(i) << LSH) || gop[i] != eop || !gwh[i]) ok = 0;
    chk(ok && tail, {req, " R6 indices/op"}, n > 0 ? gop[0] : 0, eop);
  endtask

  initial begin
    #(8 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [PA_W-1:0] s, e;
    int n;
    bit tail;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(3'd0, d);
    chk(d == 0, "R1 control word at reset", d, 0);
    chk(!mreq_valid && !cache_bypass, "R1 outputs idle at reset", {mreq_valid, cache_bypass}, 0);

    // R2 R4 directed: aligned, unaligned, each op encoding
    region(40'h0000_1000, 40'h0000_1400, 3'd0, 0, 0, "R2 aligned flush");
    region(40'h0000_2025, 40'h0000_20FF, 3'd1, 0, 0, "R2 unaligned discard R4");
    region(40'h0000_3000, 40'h0000_3100, 3'd1, 1, 0, "R4 flush-inv");
    region(40'h0000_3000, 40'h0000_3080, 3'd5, 1, 0, "R4 reserved field flush");
    // R3 empty ranges
    region(40'h0000_4010, 40'h0000_403F, 3'd0, 0, 0, "R3 same line");
    region(40'h0000_5000, 40'h0000_4000, 3'd1, 0, 0, "R3 end below start");
    // R5 high words, including crossing the 4 GiB boundary
    region(40'h12_3456_7800, 40'h12_3456_7A00, 3'd1, 1, 0, "R5 high region");
    region(40'h00_FFFF_FF80, 40'h01_0000_0080, 3'd0, 0, 0, "R5 cross 32-bit");
    // R10 disable bit drives bypass and does not stop a walk
    region(40'h0000_6000, 40'h0000_6200, 3'd0, 0, 1, "R10 walk with disable");
    chk(cache_bypass == 1, "R10 bypass follows control bit 0", cache_bypass, 1);
    wr(3'd0, 32'd0);
    chk(cache_bypass == 0, "R10 bypass cleared", cache_bypass, 0);

    // R6 whole-cache
    whole(3'd5, 0, "R6 inv-all");
    whole(3'd5, 1, "R6 inv-all flush mode");
    whole(3'd6, 0, "R6 flush-all");
    wr(3'd6, 32'd0);
    chk(!mreq_valid, "R6 zero write no start", mreq_valid, 0);

    // R9 writes during busy ignored
    wr(3'd0, 32'd0);
    wr(3'd2, 32'd0); wr(3'd1, 32'h0000_8400);
    wr(3'd4, 32'd0); wr(3'd3, 32'h0000_8000);
    chk(mreq_valid && mreq_addr == 40'h8000, "R8 first address", mreq_addr, 40'h8000);
    wr(3'd1, 32'h0009_0000);
    wr(3'd0, 32'h0000_0241);
    wr(3'd3, 32'h0000_0000);
    wr(3'd5, 32'd1);
    chk(mreq_addr == 40'h8000 && mreq_op == 2'b01, "R8 held without ack", mreq_addr, 40'h8000);
    rd(3'd1, d);
    chk(d == 32'h0000_8400, "R9 end ignored while busy", d, 32'h8400);
    rd(3'd0, d);
    chk(d == 32'h0000_0100, "R9 control ignored while busy", d, 32'h100);
    rd(3'd3, d);
    chk(d == 32'h0000_8000, "R9 start ignored while busy", d, 32'h8000);
    collect(n, tail);
    chk(n == 16 && !mreq_valid, "R9 walk not restarted", n, 16);

    // Random regions
    for (int k = 0; k < 24; k++) begin
      logic [2:0] opf;
      s = {1'b0, PA_W'($urandom) , 7'd0} ;
      s = {1'b0, 7'($urandom), $urandom} ;
      e = (s & ~PA_W'(LB - 1)) + PA_W'(($urandom % 24) * LB) + PA_W'($urandom % LB);
      opf = 3'($urandom % 3);
      region(s, e, opf, 1'($urandom), 0, "R2 random");
    end

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule